// File: doc/BRIEF.md
# Context-Banked Carry/Zero Flag Unit

This unit holds three independent carry/zero flag pairs for a small processor core. There is one pair for each execution context: normal code, maskable interrupt handlers, and non-maskable interrupt handlers. The unit tracks which context is running. It writes each flag update from the ALU into the pair that belongs to that context only, and it shows that pair to the datapath as the active carry and zero.

On entry to an interrupt or a non-maskable interrupt, the context that was running is pushed onto a small context stack and the new context takes effect at once. On a return from interrupt, the saved context is popped back. No pair is ever saved to memory or cleared by a switch. Each pair simply waits until its context runs again.

The ALU drives a set of strobes, one per kind of flag-affecting operation, with the values to load. The unit does not compute any results itself.

Top module: `ctx_flag_bank`

## Requirements
- R1: After synchronous active-low reset, the mode output is 2 (non-maskable context), all six flags are 0 and the context stack is empty.
- R2: Mode codes are 0 normal, 1 interrupt, 2 non-maskable. The cycle after `nmi_enter` the mode is 2. The cycle after `irq_enter` without `nmi_enter` the mode is 1. `nmi_enter` outranks `irq_enter`, and both outrank `ret_int`.
- R3: Each entry pushes the context that was running, and `ret_int` pops it back. For example, a non-maskable entry taken in interrupt mode returns to interrupt mode.
- R4: `ret_int` with an empty context stack selects normal mode, so a return while in normal mode leaves the mode at 0.
- R5: The context stack holds `CTX_DEPTH` (default 4) entries. Further entries drop the oldest saved context, so after an overflow the last return reaches normal mode.
- R6: `upd_arith` loads carry from `arith_carry` and zero from `arith_zero` into the active pair.
- R7: `upd_logic` loads zero from `logic_zero` and leaves carry unchanged.
- R8: `upd_bit` loads carry from `bit_val`, and `upd_rot` loads carry from `rot_carry`. Both leave zero unchanged.
- R9: When several update strobes are high together, only one takes effect, in the priority order arith, logic, bit, rotate.
- R10: A pair whose context is not running keeps its values unchanged, across any number of context switches.
- R11: An update in the same cycle as a context switch is written into the pair that was active before the switch.
- R12: `carry` and `zero` always show the pair of the current mode, including in the first cycle after a switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_enter | input | 1 | Maskable interrupt entry strobe |
| nmi_enter | input | 1 | Non-maskable interrupt entry strobe |
| ret_int | input | 1 | Return-from-interrupt strobe |
| upd_arith | input | 1 | Arithmetic result strobe |
| arith_zero | input | 1 | Arithmetic result is zero |
| arith_carry | input | 1 | Arithmetic carry or borrow |
| upd_logic | input | 1 | Logical result strobe |
| logic_zero | input | 1 | Logical result is zero |
| upd_bit | input | 1 | Bit-test strobe |
| bit_val | input | 1 | Value of the tested bit |
| upd_rot | input | 1 | Rotate strobe |
| rot_carry | input | 1 | Bit shifted out by the rotate |
| carry | output | 1 | Active carry flag |
| zero | output | 1 | Active zero flag |
| mode | output | 2 | Current context (0 normal, 1 interrupt, 2 non-maskable) |

## Verification
The case that is hardest to reach from the ports is stack overflow followed by a full unwind. It takes more nested entries than the stack holds, and then enough returns to show that the oldest context was dropped and not restored.

A directed sequence makes five interrupt entries on top of the reset context, then checks the mode after each of the five returns. Other directed steps pair flag updates with switches in the same cycle.

An exhaustive sweep then applies every one of the 4096 input vectors, in a scrambled order, against an arithmetic model of the stack and the three pairs.

// File: rtl/ctx_flag_pkg.sv
// Package: shared types for the context-banked flag unit.
// Assumes: exactly three execution contexts, encoded as two-bit mode codes.
package ctx_flag_pkg;

    typedef enum logic [1:0] {
        MODE_NORM = 2'd0,
        MODE_IRQ  = 2'd1,
        MODE_NMI  = 2'd2
    } ctx_mode_e;

    localparam int NUM_BANKS = 3;

    // One flag write request: a separate enable and value for each flag
    typedef struct packed {
        logic c_we;
        logic c_val;
        logic z_we;
        logic z_val;
    } flag_wr_t;

endpackage

// File: rtl/flag_update_sel.sv
// Module: flag_update_sel
// Turns the ALU update strobes into a single flag write request.
// Assumes: one ALU operation per cycle. If several strobes are high, the
// priority is arith > logic > bit > rotate.
module flag_update_sel
    import ctx_flag_pkg::*;
(
    input  logic     upd_arith,
    input  logic     arith_zero,
    input  logic     arith_carry,
    input  logic     upd_logic,
    input  logic     logic_zero,
    input  logic     upd_bit,
    input  logic     bit_val,
    input  logic     upd_rot,
    input  logic     rot_carry,
    output flag_wr_t wr
);

    // Priority select of the single operation that writes flags this cycle
    always_comb begin
        wr = '0;
        if (upd_arith) begin
            wr.c_we  = 1'b1;
            wr.c_val = arith_carry;
            wr.z_we  = 1'b1;
            wr.z_val = arith_zero;
        end else if (upd_logic) begin
            wr.z_we  = 1'b1;
            wr.z_val = logic_zero;
        end else if (upd_bit) begin
            wr.c_we  = 1'b1;
            wr.c_val = bit_val;
        end else if (upd_rot) begin
            wr.c_we  = 1'b1;
            wr.c_val = rot_carry;
        end
    end

endmodule

// File: rtl/flag_pair.sv
// Module: flag_pair
// One carry/zero register pair. It accepts a write only when selected.
// Assumes: the caller selects at most one pair per cycle. The reset value is 0.
module flag_pair
    import ctx_flag_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sel,
    input  flag_wr_t wr,
    output logic     c_q,
    output logic     z_q
);

    // Carry register: loads only when this pair is selected and carry is written
    always_ff @(posedge clk) begin
        if (!rst_n)
            c_q <= 1'b0;
        else if (sel && wr.c_we)
            c_q <= wr.c_val;
    end

    // Zero register: loads only when this pair is selected and zero is written
    always_ff @(posedge clk) begin
        if (!rst_n)
            z_q <= 1'b0;
        else if (sel && wr.z_we)
            z_q <= wr.z_val;
    end

endmodule

// File: rtl/ctx_mode_stack.sv
// Module: ctx_mode_stack
// Holds the current context and a shift-register stack of saved contexts.
// Entry pushes the running context. Return pops it, or falls back to normal
// mode when the stack is empty. On overflow the oldest entry is dropped.
// Assumes: nmi_enter > irq_enter > ret_int when several are high together.
module ctx_mode_stack
    import ctx_flag_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      irq_enter,
    input  logic      nmi_enter,
    input  logic      ret_int,
    output ctx_mode_e mode_q
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    ctx_mode_e        slot [DEPTH];
    logic [CNT_W-1:0] fill;
    logic             enter;

    assign enter = irq_enter | nmi_enter;

    // Current-context register: set on entry, restored on return
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= MODE_NMI;
        else if (enter)
            mode_q <= nmi_enter ? MODE_NMI : MODE_IRQ;
        else if (ret_int)
            mode_q <= (fill != '0) ? slot[0] : MODE_NORM;
    end

    // Saved-context slots: shift up on push, shift down on pop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                slot[i] <= MODE_NORM;
        end else if (enter) begin
            for (int i = DEPTH - 1; i > 0; i--)
                slot[i] <= slot[i-1];
            slot[0] <= mode_q;
        end else if (ret_int && fill != '0) begin
            for (int i = 0; i < DEPTH - 1; i++)
                slot[i] <= slot[i+1];
            slot[DEPTH-1] <= MODE_NORM;
        end
    end

    // Occupancy count: saturates at DEPTH, stops at zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill <= '0;
        else if (enter) begin
            if (fill != CNT_FULL)
                fill <= fill + 1'b1;
        end else if (ret_int && fill != '0)
            fill <= fill - 1'b1;
    end

endmodule

// File: rtl/ctx_flag_bank.sv
// Module: ctx_flag_bank (top)
// Three carry/zero pairs, one per execution context. ALU updates go to the
// pair of the context that is running in the cycle of the update. The active
// pair is presented on carry/zero.
// Assumes: the strobes are synchronous to clk. Reset is synchronous and active low.
module ctx_flag_bank
    import ctx_flag_pkg::*;
#(
    parameter int CTX_DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_enter,
    input  logic       nmi_enter,
    input  logic       ret_int,
    input  logic       upd_arith,
    input  logic       arith_zero,
    input  logic       arith_carry,
    input  logic       upd_logic,
    input  logic       logic_zero,
    input  logic       upd_bit,
    input  logic       bit_val,
    input  logic       upd_rot,
    input  logic       rot_carry,
    output logic       carry,
    output logic       zero,
    output logic [1:0] mode
);

    ctx_mode_e              cur_mode;
    flag_wr_t               wr;
    logic [NUM_BANKS-1:0]   bank_c;
    logic [NUM_BANKS-1:0]   bank_z;

    ctx_mode_stack #(.DEPTH(CTX_DEPTH)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_enter (irq_enter),
        .nmi_enter (nmi_enter),
        .ret_int   (ret_int),
        .mode_q    (cur_mode)
    );

    flag_update_sel u_sel (
        .upd_arith   (upd_arith),
        .arith_zero  (arith_zero),
        .arith_carry (arith_carry),
        .upd_logic   (upd_logic),
        .logic_zero  (logic_zero),
        .upd_bit     (upd_bit),
        .bit_val     (bit_val),
        .upd_rot     (upd_rot),
        .rot_carry   (rot_carry),
        .wr          (wr)
    );

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
        flag_pair u_pair (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (cur_mode == 2'(k)),
            .wr    (wr),
            .c_q   (bank_c[k]),
            .z_q   (bank_z[k])
        );
    end

    // Output mux: present the pair of the running context
    always_comb begin
        carry = 1'b0;
        zero  = 1'b0;
        for (int k = 0; k < NUM_BANKS; k++) begin
            if (cur_mode == 2'(k)) begin
                carry = bank_c[k];
                zero  = bank_z[k];
            end
        end
    end

    assign mode = cur_mode;

endmodule

// File: rtl/ctx_flag_bank_chk.sv
// Module: ctx_flag_bank_chk
// Property checker for ctx_flag_bank, attached by bind.
// Assumes: bank_c/bank_z are the per-context pair registers of the top module.
module ctx_flag_bank_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       irq_enter,
    input logic       nmi_enter,
    input logic       ret_int,
    input logic       upd_arith,
    input logic       arith_zero,
    input logic       arith_carry,
    input logic       upd_logic,
    input logic       logic_zero,
    input logic       carry,
    input logic       zero,
    input logic [1:0] mode,
    input logic [2:0] bank_c,
    input logic [2:0] bank_z
);

    logic no_switch;
    assign no_switch = !irq_enter && !nmi_enter && !ret_int;

    AST_RESET_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (mode == 2'd2 && carry == 1'b0 && zero == 1'b0)); // R1

    AST_NMI_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_enter |=> mode == 2'd2); // R2

    AST_IRQ_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_enter && !nmi_enter) |=> mode == 2'd1); // R2

    AST_RET_NORMAL_STAY: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_int && !irq_enter && !nmi_enter && mode == 2'd0) |=> mode == 2'd0); // R4

    AST_ARITH_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_arith && no_switch) |=>
        (carry == $past(arith_carry) && zero == $past(arith_zero))); // R6

    AST_LOGIC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_logic && !upd_arith && no_switch) |=>
        (carry == $past(carry) && zero == $past(logic_zero))); // R7

    for (genvar k = 0; k < 3; k++) begin : g_idle
        AST_IDLE_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            (mode != 2'(k)) |=> ($stable(bank_c[k]) && $stable(bank_z[k]))); // R10
    end

endmodule

bind ctx_flag_bank ctx_flag_bank_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_enter   (irq_enter),
    .nmi_enter   (nmi_enter),
    .ret_int     (ret_int),
    .upd_arith   (upd_arith),
    .arith_zero  (arith_zero),
    .arith_carry (arith_carry),
    .upd_logic   (upd_logic),
    .logic_zero  (logic_zero),
    .carry       (carry),
    .zero        (zero),
    .mode        (mode),
    .bank_c      (bank_c),
    .bank_z      (bank_z)
);

// File: tb/ctx_flag_bank_test.sv
`timescale 1ns/1ps
module ctx_flag_bank_test;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_enter, nmi_enter, ret_int;
    logic upd_arith, arith_zero, arith_carry, upd_logic, logic_zero;
    logic upd_bit, bit_val, upd_rot, rot_carry;
    logic carry, zero;
    logic [1:0] mode;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference state, built from the requirements
    int m_mode;
    int m_stk[$];
    bit m_c[3];
    bit m_z[3];

    always #10 clk = ~clk;

    ctx_flag_bank uut (
        .clk(clk), .rst_n(rst_n), .irq_enter(irq_enter), .nmi_enter(nmi_enter),
        .ret_int(ret_int), .upd_arith(upd_arith), .arith_zero(arith_zero),
        .arith_carry(arith_carry), .upd_logic(upd_logic), .logic_zero(logic_zero),
        .upd_bit(upd_bit), .bit_val(bit_val), .upd_rot(upd_rot), .rot_carry(rot_carry),
        .carry(carry), .zero(zero), .mode(mode)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Vector bits: 0 irq 1 nmi 2 ret 3 arith 4 logic 5 bit 6 rot
    //              7 az 8 ac 9 lz 10 bv 11 rc
    task automatic drive(logic [11:0] v);
        irq_enter = v[0]; nmi_enter = v[1]; ret_int = v[2];
        upd_arith = v[3]; upd_logic = v[4]; upd_bit = v[5]; upd_rot = v[6];
        arith_zero = v[7]; arith_carry = v[8]; logic_zero = v[9];
        bit_val = v[10]; rot_carry = v[11];
    endtask

    task automatic model(logic [11:0] v);
        int cur;
        cur = m_mode;
        if (v[3]) begin m_c[cur] = v[8]; m_z[cur] = v[7]; end
        else if (v[4]) m_z[cur] = v[9];
        else if (v[5]) m_c[cur] = v[10];
        else if (v[6]) m_c[cur] = v[11];
        if (v[1] || v[0]) begin
            m_stk.push_front(cur);
            if (m_stk.size() > 4) void'(m_stk.pop_back());
            m_mode = v[1] ? 2 : 1;
        end else if (v[2]) begin
            m_mode = (m_stk.size() > 0) ? m_stk.pop_front() : 0;
        end
    endtask

    // Apply one vector at a falling edge, result visible at the next falling edge
    task automatic step(logic [11:0] v);
        drive(v);
        model(v);
        @(negedge clk);
        drive(12'h000);
    endtask

    task automatic do_reset();
        drive(12'h000);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_mode = 2; m_stk.delete();
        for (int k = 0; k < 3; k++) begin m_c[k] = 0; m_z[k] = 0; end
        @(negedge clk);
    endtask

    task automatic expect3(string req, int em, int ec, int ez);
        check(req, mode, em);
        check(req, carry, ec);
        check(req, zero, ez);
    endtask

    localparam logic [11:0] V_IRQ = 12'h001, V_NMI = 12'h002, V_RET = 12'h004;

    initial begin
        drive(12'h000);
        @(negedge clk);
        do_reset();
        expect3("R1 reset", 2, 0, 0);

        step(12'h008 | 12'h080 | 12'h100); expect3("R6 arith in nmi", 2, 1, 1);
        step(V_RET);  expect3("R4 empty ret to normal", 0, 0, 0);
        step(V_RET);  expect3("R4 ret in normal", 0, 0, 0);
        step(V_IRQ);  expect3("R2 irq entry", 1, 0, 0);
        step(12'h010 | 12'h200); expect3("R7 logic z only", 1, 0, 1);
        step(V_NMI);  expect3("R10 nmi pair retained", 2, 1, 1);
        step(12'h020); expect3("R8 bit test loads c", 2, 0, 1);
        step(V_RET);  expect3("R3 nested return to irq", 1, 0, 1);
        step(12'h040 | 12'h800 | V_RET); expect3("R11 switch same cycle", 0, 0, 0);
        step(V_IRQ);  expect3("R11 update landed in irq pair", 1, 1, 1);
        step(12'h008 | 12'h010 | 12'h200); expect3("R9 arith over logic", 1, 0, 0);
        step(12'h010 | 12'h020 | 12'h400); expect3("R9 logic over bit", 1, 0, 0);
        step(12'h020 | 12'h040 | 12'h400); expect3("R9 bit over rot", 1, 1, 0);
        step(V_NMI | V_IRQ | V_RET); expect3("R2 nmi wins", 2, 0, 1);
        step(V_RET);  expect3("R3 back to irq", 1, 1, 0);

        do_reset();
        for (int i = 0; i < 5; i++) step(V_IRQ);
        check("R12 deep irq", mode, 1);
        for (int i = 0; i < 4; i++) begin
            step(V_RET);
            check("R5 unwind saved irq", mode, 1);
        end
        step(V_RET);
        check("R5 oldest dropped", mode, 0);

        do_reset();
        for (int i = 0; i < 4096; i++) begin
            logic [11:0] v;
            v = 12'((i * 1597 + 11) % 4096);
            step(v);
            check("R3 sweep mode", mode, m_mode);
            check("R12 sweep carry", carry, m_c[m_mode]);
            check("R6 sweep zero", zero, m_z[m_mode]);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run is counted as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule